// File: doc/BRIEF.md
# Audio/Video Router Control Register Slave

This block is the serial control port of an audio/video routing device. It listens on a two-wire open-drain bus, answers to one fixed 7-bit device address, and keeps the device's seven 8-bit control registers. Each register's bits drive the routing, gain, blanking and standby logic around it directly, through one flat parallel output.

A host writes by sending the device address with the direction bit clear, then a register index, then one or more data bytes. The index advances after every data byte, so a burst fills neighbouring registers. A host reads by sending the address with the direction bit set. It then clocks out one status byte, taken from the `status_i` input, with no index phase. A one-cycle strobe marks the moment the status byte has been fully shifted out, so that outside logic can clear flags that a read is meant to clear.

Both bus lines are sampled in the system clock domain through a synchronizer. The block pulls SDA low through an output-enable and never drives SCL. It does not stretch the clock and does not arbitrate with other masters.

Top module: `av_ctrl_i2c_slave`

## Requirements
- R1: After reset, every control register reads 00h on `ctrl_o`, `sda_oe_o` is low and `rd_strobe_o` is low.
- R2: The device address is 1001011b, so the write address byte is 96h and the read address byte is 97h. Both are acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the rest of that transfer changes no register and returns no data.
- R3: In a write, the index byte and every data byte are acknowledged, and the first data byte is stored in the register whose index was sent.
- R4: Each further data byte in the same write goes to the next register index. Register n appears on `ctrl_o[8n+7:8n]`.
- R5: A data byte whose index is 07h or above is acknowledged but stored nowhere. The index stops advancing once it passes 06h, so a burst that runs past the last register leaves registers 00h to 06h as the earlier bytes set them.
- R6: In a read, the status byte is shifted out MSB first, starting right after the address acknowledge. No index byte is expected.
- R7: `rd_strobe_o` pulses high for exactly one clock after the eighth status bit has been clocked out, once per read. SDA is released in that cycle.
- R8: A START received at any point, including a repeated START inside a transfer, begins a new address phase. A STOP ends the transfer and releases SDA.
- R9: An asynchronous reset during operation returns all registers to 00h, whatever the bus is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least ten times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| status_i | input | 8 | Status byte returned by a read |
| rd_strobe_o | output | 1 | One-cycle pulse when the status byte has been sent |
| ctrl_o | output | 56 | Register n on bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: the fixed device address, seven registers and a two-stage synchronizer. With seven registers, one burst can reach the end of the bank. A burst started at index 05h therefore covers the saturation boundary, and a write to index 09h covers a start beyond the bank. The bus is driven with 40 system clocks per SCL bit. This leaves the synchronizer delay well inside each low phase, so the acknowledge and read-data timing is checked against the real open-drain line the bench models.

// File: rtl/av_i2c_pkg.sv
package av_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } bus_state_e;
endpackage

// File: rtl/av_i2c_sync.sv
module av_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // extra top bit holds the previous synchronized sample
  logic [STAGES:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_pipe[STAGES-1];
  assign scl_q = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/av_i2c_engine.sv
module av_i2c_engine
  import av_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001011,
  parameter int         NUM_REGS = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       rd_strobe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  localparam logic [7:0] PTR_END = 8'(NUM_REGS);

  bus_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, ptr_q;
  logic       rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      sda_oe_o    <= 1'b0;
      rd_strobe_o <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o     <= 1'b0;
      rd_strobe_o <= 1'b0;
      if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q     <= sh_q[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q  <= ST_IDLE;
                end
              end else if (state_q == ST_SUB) begin
                ptr_q    <= sh_q;
                sda_oe_o <= 1'b1;
                state_q  <= ST_SUB_ACK;
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= sh_q;
                if (ptr_q < PTR_END) ptr_q <= ptr_q + 8'd1;
                sda_oe_o  <= 1'b1;
                state_q   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q     <= status_i;
                sda_oe_o <= ~status_i[7];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o    <= 1'b0;
                rd_strobe_o <= 1'b1;
                state_q     <= ST_RACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          ST_RACK: if (scl_rise_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/av_i2c_regbank.sv
module av_i2c_regbank #(
  parameter int NUM_REGS = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] ctrl_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_o[g*8 +: 8] <= '0;
      else if (wr_en_i && wr_addr_i == 8'(g)) ctrl_o[g*8 +: 8] <= wr_data_i;
    end
  end
endmodule

// File: rtl/av_ctrl_i2c_slave.sv
module av_ctrl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001011,
  parameter int         NUM_REGS    = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [7:0]            status_i,
  output logic                  rd_strobe_o,
  output logic [NUM_REGS*8-1:0] ctrl_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;

  av_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  av_i2c_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .status_i,
    .sda_oe_o, .rd_strobe_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  av_i2c_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o
  );
endmodule

// File: rtl/av_ctrl_i2c_slave_chk.sv
module av_ctrl_i2c_slave_chk #(
  parameter int NUM_REGS = 7
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic                  rd_strobe_o,
  input logic [NUM_REGS*8-1:0] ctrl_o
);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (ctrl_o == '0 && !sda_oe_o && !rd_strobe_o));

  // registers only change while the bus clock is low (after a byte ends)
  assert_write_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> !scl_i);

  // the slave only starts pulling SDA while SCL is low
  assert_drive_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_o |=> !rd_strobe_o);

  assert_strobe_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_o |-> !sda_oe_o);
endmodule

bind av_ctrl_i2c_slave av_ctrl_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .rd_strobe_o(rd_strobe_o), .ctrl_o(ctrl_o)
);

// File: tb/av_ctrl_i2c_slave_bench.sv
`timescale 1ns/1ps
module av_ctrl_i2c_slave_bench;
  localparam int NR = 7;
  localparam int Q  = 10;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [7:0] status = 8'h00;
  logic sda_oe, rd_strobe;
  logic [NR*8-1:0] ctrl;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  av_ctrl_i2c_slave u_av_ctrl_i2c_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .status_i(status), .rd_strobe_o(rd_strobe), .ctrl_o(ctrl)
  );

  int n_chk = 0, n_bad = 0, n_strobe = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [NR];
  logic [7:0] buf_q [9];

  always @(posedge clk) if (rd_strobe) n_strobe++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    logic [NR*8-1:0] e;
    for (int i = 0; i < NR; i++) e[i*8 +: 8] = exp_r[i];
    check(ctrl === e, req, "ctrl_o", 64'(ctrl), 64'(e));
  endtask

  task automatic wq; repeat (Q) @(posedge clk); #1; endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl = 1'b1; wq; ack = !sda_line; wq; scl = 1'b0; wq;
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl = 1'b1; wq; b[i] = sda_line; wq; scl = 1'b0;
    end
    wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;  // master NACK
  endtask

  // write n bytes from buf_q starting at sub; model per R3/R4/R5
  task automatic do_write(input logic [7:0] sub, input int n, input string req);
    bit ack;
    int ptr = sub;
    bus_start;
    send_byte(8'h96, ack); check(ack, "R2", "write address ack", 64'(ack), 1);
    send_byte(sub, ack);   check(ack, "R3", "index ack", 64'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(buf_q[k], ack);
      check(ack, req, "data ack", 64'(ack), 1);
      if (ptr < NR) begin exp_r[ptr] = buf_q[k]; ptr++; end
    end
    bus_stop;
    check_regs(req);
  endtask

  task automatic t_reset;
    check_regs("R1");
    check(sda_oe === 1'b0 && rd_strobe === 1'b0, "R1", "bus outputs idle",
          64'({sda_oe, rd_strobe}), 0);
  endtask

  task automatic t_single;
    buf_q[0] = 8'hA5;
    do_write(8'h02, 1, "R3");
  endtask

  task automatic t_burst;
    for (int k = 0; k < NR; k++) buf_q[k] = 8'h11 * 8'(k + 1) ^ 8'h80;
    do_write(8'h00, NR, "R4");
  endtask

  task automatic t_overrun;
    buf_q[0] = 8'h3C; buf_q[1] = 8'hE7; buf_q[2] = 8'h55; buf_q[3] = 8'hAA;
    do_write(8'h05, 4, "R5");
    buf_q[0] = 8'hFF; buf_q[1] = 8'h00;
    do_write(8'h09, 2, "R5");
  endtask

  task automatic t_bad_addr;
    bit ack;
    bus_start; send_byte(8'h94, ack);
    check(!ack, "R2", "foreign write address nack", 64'(ack), 0);
    send_byte(8'h01, ack); send_byte(8'h77, ack);
    bus_stop; check_regs("R2");
    bus_start; send_byte(8'h17, ack);
    check(!ack, "R2", "foreign read address nack", 64'(ack), 0);
    bus_stop;
    check(n_strobe == 0, "R2", "no strobe on foreign read", 64'(n_strobe), 0);
  endtask

  task automatic t_read(input logic [7:0] st);
    bit ack; logic [7:0] got; int s0 = n_strobe;
    status = st;
    bus_start; send_byte(8'h97, ack);
    check(ack, "R2", "read address ack", 64'(ack), 1);
    read_byte(got);
    check(got === st, "R6", "status byte", 64'(got), 64'(st));
    bus_stop;
    check(n_strobe == s0 + 1, "R7", "one strobe per read", 64'(n_strobe), 64'(s0 + 1));
    check(sda_oe === 1'b0, "R7", "sda released after read", 64'(sda_oe), 0);
    check_regs("R6");
  endtask

  task automatic t_restart;
    bit ack; logic [7:0] got;
    status = 8'h81;
    bus_start; send_byte(8'h96, ack); send_byte(8'h01, ack);
    send_byte(8'h4D, ack); exp_r[1] = 8'h4D;
    bus_start; send_byte(8'h97, ack);
    check(ack, "R8", "address ack after repeated start", 64'(ack), 1);
    read_byte(got);
    check(got === 8'h81, "R8", "status after repeated start", 64'(got), 8'h81);
    bus_stop;
    check_regs("R8");
    check(sda_oe === 1'b0, "R8", "released after stop", 64'(sda_oe), 0);
  endtask

  task automatic t_async_reset;
    bit ack;
    bus_start; send_byte(8'h96, ack); send_byte(8'h00, ack);
    rst_ni = 1'b0; repeat (3) @(posedge clk); #1;
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    check_regs("R9");
    scl = 1'b1; sda_m = 1'b1; wq;
    rst_ni = 1'b1; wq;
    buf_q[0] = 8'h6B;
    do_write(8'h04, 1, "R9");
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    repeat (4) @(posedge clk); #1;
    t_reset;
    rst_ni = 1'b1; wq;
    t_reset;
    t_single;
    t_bad_addr;
    t_burst;
    t_overrun;
    t_read(8'h5A);
    t_read(8'hC3);
    t_restart;
    t_async_reset;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule